// File: doc/BRIEF.md
# Virtual Interrupt Completion and Deactivation Controller

This block sits behind the guest side of a virtual CPU interface. It handles two kinds of guest write: end-of-interrupt (EOI), which drops the running priority and normally retires the interrupt, and deactivate (DIR), which only retires it. It holds four list entries, each describing one virtual interrupt, a 32-bit active-priorities register and a hypervisor control word that carries a completion-miss count. The hypervisor loads list entries, the active-priorities register and the count through its own write ports.

Every guest write is resolved in one clock cycle into one of six named actions. IDLE means no write. IGNORE means the write has no effect. EOI_HIT drops a priority and clears the active state of the matching entry. EOI_MISS drops a priority and increments the count. DIR_HIT clears the active state of the matching entry. DIR_MISS increments the count. A completion that names an interrupt the list does not hold as active is counted, so the hypervisor can see it.

Top module: `veoi_ctrl`

## Requirements
- R1: A guest write that finds no active list entry for its ID and is not otherwise ignored increments the count by exactly one and changes no list entry.
- R2: A guest write with ID 1020 to 1023, to either register, is ignored: list entries, the active-priorities register and the count all stay unchanged.
- R3: An EOI (g_sel_i = 0) while the active-priorities register is zero is ignored. Otherwise it clears exactly the lowest-numbered set bit of that register.
- R4: An EOI that clears a priority bit and finds a match clears the active state of the matched entry. If it finds no match, it increments the count.
- R5: A DIR (g_sel_i = 1) never changes the active-priorities register. A match clears the active state of the matched entry; no match increments the count.
- R6: A DIR while g_eoi_mode_i is 0 is ignored entirely, whatever its ID.
- R7: Every ID from 0 to 1019 takes part in the list search. No other limit on the ID applies; for example, an entry holding ID 1019 matches.
- R8: A list entry is 17 bits: [9:0] virtual ID, [14:10] priority, [16:15] state, with 00 invalid, 01 pending, 10 active and 11 pending-and-active. An entry matches when its state is 10 or 11. Clearing active turns 10 into 00 and 11 into 01. Entry i sits in lr_o[17*i+16:17*i].
- R9: When several entries match, the lowest-indexed one is used.
- R10: The count sits in hcr_o[31:27] and wraps modulo 32. hcr_o[26:0] reads zero.
- R11: The hypervisor ports write a list entry, the active-priorities register or the count. A hypervisor write takes precedence over a guest update of the same register in the same cycle.
- R12: An active-high synchronous reset clears all list entries, the active-priorities register and the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| g_we_i | input | 1 | Guest write strobe |
| g_sel_i | input | 1 | Register select: 0 EOI, 1 DIR |
| g_id_i | input | 10 | Interrupt ID carried by the guest write |
| g_eoi_mode_i | input | 1 | Split completion mode; DIR is honoured only when 1 |
| hv_lr_we_i | input | 1 | Hypervisor list entry write strobe |
| hv_lr_idx_i | input | 2 | Index of the list entry to write |
| hv_lr_data_i | input | 17 | List entry value |
| hv_apr_we_i | input | 1 | Hypervisor active-priorities write strobe |
| hv_apr_data_i | input | 32 | Active-priorities value |
| hv_cnt_we_i | input | 1 | Hypervisor count write strobe |
| hv_cnt_data_i | input | 5 | Count value |
| lr_o | output | 68 | All list entries, entry i in bits 17*i+16:17*i |
| apr_o | output | 32 | Active-priorities register |
| hcr_o | output | 32 | Control word with the count in bits 31:27 |

## Verification
The hardest case to reach is a completion that passes every gate and still misses. For an EOI this means the active-priorities register must be non-zero while no entry with that ID is active. The stimulus reaches it by loading a pending-only entry and then issuing an EOI that names it. The lowest-index rule needs two active entries that hold the same ID; after the first EOI retires entry 0, a second EOI must land on entry 3. Count wrap is reached by writing 31 through the hypervisor port and then issuing a DIR miss. A further case has a guest DIR miss and a hypervisor count write arrive in the same cycle.

// File: rtl/veoi_pkg.sv
package veoi_pkg;

    typedef enum logic [1:0] {
        ST_INVALID  = 2'b00,
        ST_PENDING  = 2'b01,
        ST_ACTIVE   = 2'b10,
        ST_PEND_ACT = 2'b11
    } lr_state_e;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_IGNORE,
        ACT_EOI_HIT,
        ACT_EOI_MISS,
        ACT_DIR_HIT,
        ACT_DIR_MISS
    } act_e;

    localparam logic SEL_EOI = 1'b0;
    localparam logic SEL_DIR = 1'b1;
    localparam int   SPECIAL_ID_BASE = 1020;

endpackage

// File: rtl/veoi_lr_match.sv
module veoi_lr_match #(
    parameter int NUM_LR = 4,
    parameter int VID_W  = 10,
    parameter int LR_W   = 17,
    parameter int IDX_W  = 2
) (
    input  logic [NUM_LR*LR_W-1:0] lr_flat_i,
    input  logic [VID_W-1:0]       id_i,
    output logic                   hit_o,
    output logic [IDX_W-1:0]       idx_o
);
    logic [NUM_LR-1:0] cand;

    for (genvar i = 0; i < NUM_LR; i++) begin : g_cand
        // Top state bit set means active or pending-and-active.
        assign cand[i] = lr_flat_i[i*LR_W + LR_W - 1] &&
                         (lr_flat_i[i*LR_W +: VID_W] == id_i);
    end

    always_comb begin
        idx_o = '0;
        for (int i = NUM_LR - 1; i >= 0; i--) begin
            if (cand[i]) idx_o = IDX_W'(i);
        end
    end

    assign hit_o = |cand;
endmodule

// File: rtl/veoi_apr_drop.sv
module veoi_apr_drop #(
    parameter int APR_W = 32
) (
    input  logic [APR_W-1:0] apr_i,
    output logic             any_o,
    output logic [APR_W-1:0] apr_next_o
);
    // Removing the lowest set bit retires the highest active priority group.
    assign any_o      = |apr_i;
    assign apr_next_o = apr_i & (apr_i - APR_W'(1));
endmodule

// File: rtl/veoi_ctrl.sv
module veoi_ctrl #(
    parameter int NUM_LR = 4,
    parameter int VID_W  = 10,
    parameter int PRIO_W = 5,
    parameter int APR_W  = 32,
    parameter int CNT_W  = 5,
    parameter int HCR_W  = 32
) (
    input  logic                               clk_i,
    input  logic                               rst_i,
    input  logic                               g_we_i,
    input  logic                               g_sel_i,
    input  logic [VID_W-1:0]                   g_id_i,
    input  logic                               g_eoi_mode_i,
    input  logic                               hv_lr_we_i,
    input  logic [$clog2(NUM_LR)-1:0]          hv_lr_idx_i,
    input  logic [VID_W+PRIO_W+1:0]            hv_lr_data_i,
    input  logic                               hv_apr_we_i,
    input  logic [APR_W-1:0]                   hv_apr_data_i,
    input  logic                               hv_cnt_we_i,
    input  logic [CNT_W-1:0]                   hv_cnt_data_i,
    output logic [NUM_LR*(VID_W+PRIO_W+2)-1:0] lr_o,
    output logic [APR_W-1:0]                   apr_o,
    output logic [HCR_W-1:0]                   hcr_o
);
    import veoi_pkg::*;

    localparam int LR_W  = VID_W + PRIO_W + 2;
    localparam int IDX_W = $clog2(NUM_LR);
    localparam logic [VID_W-1:0] SPECIAL_ID = VID_W'(SPECIAL_ID_BASE);

    logic [LR_W-1:0]  lr_q [NUM_LR];
    logic [LR_W-1:0]  lr_d [NUM_LR];
    logic [APR_W-1:0] apr_q, apr_d, apr_dropped;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             apr_any, hit, special;
    logic [IDX_W-1:0] hit_idx;
    act_e             act;

    for (genvar i = 0; i < NUM_LR; i++) begin : g_flat
        assign lr_o[i*LR_W +: LR_W] = lr_q[i];
    end

    veoi_lr_match #(
        .NUM_LR (NUM_LR),
        .VID_W  (VID_W),
        .LR_W   (LR_W),
        .IDX_W  (IDX_W)
    ) u_match (
        .lr_flat_i (lr_o),
        .id_i      (g_id_i),
        .hit_o     (hit),
        .idx_o     (hit_idx)
    );

    veoi_apr_drop #(
        .APR_W (APR_W)
    ) u_drop (
        .apr_i      (apr_q),
        .any_o      (apr_any),
        .apr_next_o (apr_dropped)
    );

    assign special = (g_id_i >= SPECIAL_ID);

    // Decide the action for this cycle's guest write.
    always_comb begin
        act = ACT_IDLE;
        if (g_we_i) begin
            if (g_sel_i == SEL_DIR) begin
                if (!g_eoi_mode_i || special) act = ACT_IGNORE;
                else if (hit)                 act = ACT_DIR_HIT;
                else                          act = ACT_DIR_MISS;
            end else begin
                if (special || !apr_any)      act = ACT_IGNORE;
                else if (hit)                 act = ACT_EOI_HIT;
                else                          act = ACT_EOI_MISS;
            end
        end
    end

    // Next-state values per action; hypervisor writes override afterwards.
    always_comb begin
        lr_d  = lr_q;
        apr_d = apr_q;
        cnt_d = cnt_q;
        unique case (act)
            ACT_IDLE, ACT_IGNORE: begin
            end
            ACT_EOI_HIT: begin
                apr_d                   = apr_dropped;
                lr_d[hit_idx][LR_W - 1] = 1'b0;
            end
            ACT_EOI_MISS: begin
                apr_d = apr_dropped;
                cnt_d = cnt_q + CNT_W'(1);
            end
            ACT_DIR_HIT: begin
                lr_d[hit_idx][LR_W - 1] = 1'b0;
            end
            ACT_DIR_MISS: begin
                cnt_d = cnt_q + CNT_W'(1);
            end
            default: begin
            end
        endcase
        if (hv_lr_we_i)  lr_d[hv_lr_idx_i] = hv_lr_data_i;
        if (hv_apr_we_i) apr_d             = hv_apr_data_i;
        if (hv_cnt_we_i) cnt_d             = hv_cnt_data_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int i = 0; i < NUM_LR; i++) lr_q[i] <= '0;
            apr_q <= '0;
            cnt_q <= '0;
        end else begin
            lr_q  <= lr_d;
            apr_q <= apr_d;
            cnt_q <= cnt_d;
        end
    end

    assign apr_o = apr_q;
    assign hcr_o = {cnt_q, {(HCR_W - CNT_W){1'b0}}};

endmodule

// File: rtl/veoi_ctrl_chk.sv
module veoi_ctrl_chk #(
    parameter int NUM_LR = 4,
    parameter int VID_W  = 10,
    parameter int PRIO_W = 5,
    parameter int APR_W  = 32,
    parameter int CNT_W  = 5,
    parameter int HCR_W  = 32
) (
    input logic                               clk_i,
    input logic                               rst_i,
    input logic                               g_we_i,
    input logic                               g_sel_i,
    input logic [VID_W-1:0]                   g_id_i,
    input logic                               g_eoi_mode_i,
    input logic                               hv_lr_we_i,
    input logic                               hv_apr_we_i,
    input logic                               hv_cnt_we_i,
    input logic [NUM_LR*(VID_W+PRIO_W+2)-1:0] lr_o,
    input logic [APR_W-1:0]                   apr_o,
    input logic [HCR_W-1:0]                   hcr_o
);
    logic             no_hv;
    logic             special;
    logic [CNT_W-1:0] cnt;

    assign no_hv   = !hv_lr_we_i && !hv_apr_we_i && !hv_cnt_we_i;
    assign special = (g_id_i >= VID_W'(1020));
    assign cnt     = hcr_o[HCR_W-1 -: CNT_W];

    p_special_ignored_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (g_we_i && special && no_hv) |=> ($stable(lr_o) && $stable(apr_o) && $stable(hcr_o)));

    p_eoi_empty_ignored_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (g_we_i && !g_sel_i && (apr_o == '0) && no_hv) |=> ($stable(lr_o) && $stable(hcr_o) && $stable(apr_o)));

    p_eoi_one_bit_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (g_we_i && !g_sel_i && !special && (apr_o != '0) && !hv_apr_we_i)
        |=> ($countones(apr_o) + 1 == $countones($past(apr_o))));

    p_dir_keeps_apr_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (g_we_i && g_sel_i && !hv_apr_we_i) |=> $stable(apr_o));

    p_dir_mode_off_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (g_we_i && g_sel_i && !g_eoi_mode_i && no_hv) |=> ($stable(lr_o) && $stable(apr_o) && $stable(hcr_o)));

    p_count_step_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (!hv_cnt_we_i) |=> ((cnt == $past(cnt)) || (cnt == CNT_W'($past(cnt) + 1'b1))));

    p_low_bits_zero_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |-> (hcr_o[HCR_W-CNT_W-1:0] == '0));

    p_quiet_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        (!g_we_i && no_hv) |=> ($stable(lr_o) && $stable(apr_o) && $stable(hcr_o)));

endmodule

bind veoi_ctrl veoi_ctrl_chk #(
    .NUM_LR (NUM_LR),
    .VID_W  (VID_W),
    .PRIO_W (PRIO_W),
    .APR_W  (APR_W),
    .CNT_W  (CNT_W),
    .HCR_W  (HCR_W)
) u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .g_we_i       (g_we_i),
    .g_sel_i      (g_sel_i),
    .g_id_i       (g_id_i),
    .g_eoi_mode_i (g_eoi_mode_i),
    .hv_lr_we_i   (hv_lr_we_i),
    .hv_apr_we_i  (hv_apr_we_i),
    .hv_cnt_we_i  (hv_cnt_we_i),
    .lr_o         (lr_o),
    .apr_o        (apr_o),
    .hcr_o        (hcr_o)
);

// File: tb/sim_veoi_ctrl.sv
module sim_veoi_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic        g_we, g_sel, g_eoi_mode;
    logic [9:0]  g_id;
    logic        hv_lr_we, hv_apr_we, hv_cnt_we;
    logic [1:0]  hv_lr_idx;
    logic [16:0] hv_lr_data;
    logic [31:0] hv_apr_data;
    logic [4:0]  hv_cnt_data;
    logic [67:0] lr_o;
    logic [31:0] apr_o, hcr_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    veoi_ctrl u0 (
        .clk_i         (clk),
        .rst_i         (rst),
        .g_we_i        (g_we),
        .g_sel_i       (g_sel),
        .g_id_i        (g_id),
        .g_eoi_mode_i  (g_eoi_mode),
        .hv_lr_we_i    (hv_lr_we),
        .hv_lr_idx_i   (hv_lr_idx),
        .hv_lr_data_i  (hv_lr_data),
        .hv_apr_we_i   (hv_apr_we),
        .hv_apr_data_i (hv_apr_data),
        .hv_cnt_we_i   (hv_cnt_we),
        .hv_cnt_data_i (hv_cnt_data),
        .lr_o          (lr_o),
        .apr_o         (apr_o),
        .hcr_o         (hcr_o)
    );

    // Vector fields: req[86:83] kind[82:81] sel[80] mode[79] idx[78:77]
    // data[76:45] exp_cnt[44:40] exp_apr[39:8] exp_states[7:0] (entry 3..0)
    // kind: 0 guest write, 1 list entry write, 2 priorities write, 3 count write
    localparam int NV = 21;
    localparam logic [86:0] VEC [NV] = '{
        {4'd11, 2'd1, 1'b0, 1'b0, 2'd0, 32'h0001_0C28, 5'd0,  32'h0000_0000, 8'h02}, // R11 entry0 active id40
        {4'd11, 2'd1, 1'b0, 1'b0, 2'd1, 32'h0001_9029, 5'd0,  32'h0000_0000, 8'h0E}, // R11 entry1 pend+act id41
        {4'd11, 2'd1, 1'b0, 1'b0, 2'd2, 32'h0000_802A, 5'd0,  32'h0000_0000, 8'h1E}, // R11 entry2 pending id42
        {4'd11, 2'd1, 1'b0, 1'b0, 2'd3, 32'h0001_0428, 5'd0,  32'h0000_0000, 8'h9E}, // R11 entry3 active id40
        {4'd11, 2'd2, 1'b0, 1'b0, 2'd0, 32'h0000_0018, 5'd0,  32'h0000_0018, 8'h9E}, // R11 priorities
        {4'd9,  2'd0, 1'b0, 1'b0, 2'd0, 32'd40,        5'd0,  32'h0000_0010, 8'h9C}, // R9 EOI picks entry0
        {4'd4,  2'd0, 1'b0, 1'b0, 2'd0, 32'd42,        5'd1,  32'h0000_0000, 8'h9C}, // R4 EOI miss on pending
        {4'd3,  2'd0, 1'b0, 1'b0, 2'd0, 32'd41,        5'd1,  32'h0000_0000, 8'h9C}, // R3 EOI with empty priorities
        {4'd11, 2'd2, 1'b0, 1'b0, 2'd0, 32'h8000_0001, 5'd1,  32'h8000_0001, 8'h9C}, // R11
        {4'd2,  2'd0, 1'b0, 1'b0, 2'd0, 32'd1021,      5'd1,  32'h8000_0001, 8'h9C}, // R2 EOI special
        {4'd6,  2'd0, 1'b1, 1'b0, 2'd0, 32'd41,        5'd1,  32'h8000_0001, 8'h9C}, // R6 DIR mode off
        {4'd5,  2'd0, 1'b1, 1'b1, 2'd0, 32'd41,        5'd1,  32'h8000_0001, 8'h94}, // R5 DIR hit 11->01
        {4'd1,  2'd0, 1'b1, 1'b1, 2'd0, 32'd99,        5'd2,  32'h8000_0001, 8'h94}, // R1 DIR miss
        {4'd2,  2'd0, 1'b1, 1'b1, 2'd0, 32'd1023,      5'd2,  32'h8000_0001, 8'h94}, // R2 DIR special
        {4'd8,  2'd0, 1'b0, 1'b0, 2'd0, 32'd40,        5'd2,  32'h8000_0000, 8'h14}, // R8 EOI hits entry3 10->00
        {4'd10, 2'd3, 1'b0, 1'b0, 2'd0, 32'd31,        5'd31, 32'h8000_0000, 8'h14}, // R10 count preset
        {4'd10, 2'd0, 1'b1, 1'b1, 2'd0, 32'd500,       5'd0,  32'h8000_0000, 8'h14}, // R10 wrap
        {4'd11, 2'd1, 1'b0, 1'b0, 2'd0, 32'h0001_03FB, 5'd0,  32'h8000_0000, 8'h16}, // R11 entry0 id1019
        {4'd7,  2'd0, 1'b1, 1'b1, 2'd0, 32'd1019,      5'd0,  32'h8000_0000, 8'h14}, // R7 id1019 matches
        {4'd7,  2'd0, 1'b1, 1'b1, 2'd0, 32'd1019,      5'd1,  32'h8000_0000, 8'h14}, // R7 now a miss
        {4'd2,  2'd0, 1'b0, 1'b0, 2'd0, 32'd1020,      5'd1,  32'h8000_0000, 8'h14}  // R2 boundary 1020
    };

    function automatic logic [7:0] states();
        return {lr_o[67:66], lr_o[50:49], lr_o[33:32], lr_o[16:15]};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        g_we = 0; g_sel = 0; g_eoi_mode = 0; g_id = '0;
        hv_lr_we = 0; hv_apr_we = 0; hv_cnt_we = 0;
        hv_lr_idx = '0; hv_lr_data = '0; hv_apr_data = '0; hv_cnt_data = '0;
    endtask

    task automatic run_vec(input logic [86:0] v);
        string tag;
        tag = $sformatf("R%0d", v[86:83]);
        unique case (v[82:81])
            2'd0: begin g_we = 1; g_sel = v[80]; g_eoi_mode = v[79]; g_id = v[54:45]; end
            2'd1: begin hv_lr_we = 1; hv_lr_idx = v[78:77]; hv_lr_data = v[61:45]; end
            2'd2: begin hv_apr_we = 1; hv_apr_data = v[76:45]; end
            default: begin hv_cnt_we = 1; hv_cnt_data = v[49:45]; end
        endcase
        @(negedge clk);
        idle_inputs();
        chk(tag, "count", {27'd0, hcr_o[31:27]}, {27'd0, v[44:40]});
        chk(tag, "priorities", apr_o, v[39:8]);
        chk(tag, "states", {24'd0, states()}, {24'd0, v[7:0]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R12 watchdog: actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        rst = 1;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12", "lr after reset", {31'd0, lr_o != '0}, 32'd0);
        chk("R12", "apr after reset", apr_o, 32'd0);
        chk("R12", "hcr after reset", hcr_o, 32'd0);
        rst = 0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R10 bits below the count read zero
        chk("R10", "hcr low bits", {5'd0, hcr_o[26:0]}, 32'd0);

        // R11 hypervisor count write beats a guest DIR miss in the same cycle
        g_we = 1; g_sel = 1; g_eoi_mode = 1; g_id = 10'd77;
        hv_cnt_we = 1; hv_cnt_data = 5'd5;
        @(negedge clk);
        idle_inputs();
        chk("R11", "count on collision", {27'd0, hcr_o[31:27]}, 32'd5);

        // R12 reset in mid-run clears everything
        rst = 1;
        @(negedge clk);
        rst = 0;
        chk("R12", "lr after late reset", {31'd0, lr_o != '0}, 32'd0);
        chk("R12", "apr after late reset", apr_o, 32'd0);
        chk("R12", "hcr after late reset", hcr_o, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule